// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the lowest address bits that a synchronous memory array uses during a four-beat burst. A burst begins when the controller pulses the load strobe with the starting low-order address bits. That starting value is presented unchanged as the first beat. After that, each pulse on the advance strobe steps to the next beat. After the fourth beat the sequence wraps back to the starting address. When neither strobe is active, the output holds its value.

Two orderings are supported. In linear order, each beat is the start address plus the beat count, modulo four. In interleaved order, each beat is the start address XOR the beat count. The order select pin is a quasi-static level. The block samples it together with the load strobe, so the order stays fixed for the whole burst. Interleaved order is the default: a low level selects linear, and a high level selects interleaved. A board pull-up holds the pin high when it is left unconnected.

Top module: `burst_addr_seq`

## Requirements
- R1: During reset and on the first cycle after `rst_n` is released, `addr_o` reads 00.
- R2: A cycle with `load_i` high makes `addr_o` equal to that cycle's `start_i` from the next clock edge on, and restarts the beat count at zero.
- R3: With `order_sel_i` low at load, successive advances produce start+1, start+2, start+3 (modulo 4). For example, 01 gives 01, 10, 11, 00 and 11 gives 11, 00, 01, 10.
- R4: With `order_sel_i` high at load, successive advances produce start^1, start^2, start^3. For example, 01 gives 01, 00, 11, 10 and 11 gives 11, 10, 01, 00.
- R5: A fifth beat, meaning a fourth advance after the load, returns `addr_o` to the start address, and the sequence repeats.
- R6: A cycle with both `load_i` and `adv_i` low leaves `addr_o` unchanged.
- R7: When `load_i` and `adv_i` are both high in the same cycle, the load wins and `addr_o` becomes `start_i`.
- R8: A change of `order_sel_i` between loads has no effect on the running burst. The next load picks up the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Start a burst from `start_i` |
| start_i | input | BEAT_W | Starting low-order address bits |
| adv_i | input | 1 | Step to the next beat |
| order_sel_i | input | 1 | 0 = linear, 1 = interleaved; sampled on load |
| addr_o | output | BEAT_W | Current low-order address bits for the array |

## Verification
The hardest case to reach is a collision between orderings. The order pin is flipped in the middle of a burst, and the output must keep following the order that was captured at load. The stimulus loads an interleaved burst and then toggles `order_sel_i` low before each advance, so a design that reads the pin directly diverges on the second beat. Same-cycle load and advance at every start value, and runs of more than four advances, cover the priority and wrap cases.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_seq_pkg;

    // Burst order captured at load time.
    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_start_reg.sv
// Module: burst_start_reg
// Captures the starting address and the burst order on each load.
// Assumes: order_sel_i is stable around the load cycle; a low level selects
// linear order and anything else selects interleaved order.
module burst_start_reg
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic              order_sel_i,
    output logic [BEAT_W-1:0] start_o,
    output burst_order_e      order_o
);

    // Hold the start address and order; refresh them only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= '0;
            order_o <= ORD_INTERLEAVE;
        end else if (load_i) begin
            start_o <= start_i;
            if (order_sel_i == 1'b0) order_o <= ORD_LINEAR;
            else                     order_o <= ORD_INTERLEAVE;
        end
    end

    // R2: the start register follows the loaded value.
    assert_start_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> start_o == $past(start_i));

    // R8: without a load the captured order never moves.
    assert_order_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(order_o));

endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Counts beats within a burst; load clears it, advance steps it, wrapping
// naturally at 2**BEAT_W beats.
// Assumes: load has priority over advance.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [BEAT_W-1:0] beat_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    // Beat counter: clear on load, increment on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      beat_o <= '0;
        else if (load_i) beat_o <= '0;
        else if (adv_i)  beat_o <= beat_o + 1'b1;
    end

    // R2 / R7: any load restarts the count, even with advance high.
    assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> beat_o == '0);

    // R5: advancing from the last beat wraps to beat zero.
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && beat_o == LAST_BEAT) |=> beat_o == '0);

    // R6: idle cycles keep the count.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(beat_o));

endmodule

// File: rtl/burst_addr_map.sv
// Module: burst_addr_map
// Combines start address and beat count into the array address.
// Assumes: order_i is constant for a burst. LINEAR_EN = 0 builds an
// interleave-only variant that ignores order_i.
module burst_addr_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W    = 2,
    parameter bit LINEAR_EN = 1'b1
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  burst_order_e      order_i,
    output logic [BEAT_W-1:0] addr_o
);

    logic [BEAT_W-1:0] xor_addr;
    logic [BEAT_W-1:0] add_addr;

    // Both candidate addresses; the add wraps modulo 2**BEAT_W.
    always_comb begin
        xor_addr = start_i ^ beat_i;
        add_addr = start_i + beat_i;
    end

    generate
        if (LINEAR_EN) begin : g_both
            // Pick the candidate for the captured order.
            always_comb addr_o = (order_i == ORD_LINEAR) ? add_addr : xor_addr;
        end else begin : g_xor_only
            // Interleave-only build: the order input is unused by design.
            logic unused_order;
            always_comb unused_order = order_i[0];
            always_comb addr_o = xor_addr;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Low-order burst address sequencer: load a start value, then step it in
// linear or interleaved order with wrap after 2**BEAT_W beats.
// Assumes: synchronous active-low reset; order_sel_i is quasi-static and is
// only sampled on load.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic              adv_i,
    input  logic              order_sel_i,
    output logic [BEAT_W-1:0] addr_o
);

    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    burst_order_e      order_q;

    burst_start_reg #(.BEAT_W(BEAT_W)) u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .start_i     (start_i),
        .order_sel_i (order_sel_i),
        .start_o     (start_q),
        .order_o     (order_q)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .adv_i  (adv_i),
        .beat_o (beat_q)
    );

    burst_addr_map #(.BEAT_W(BEAT_W), .LINEAR_EN(1'b1)) u_map (
        .start_i (start_q),
        .beat_i  (beat_q),
        .order_i (order_q),
        .addr_o  (addr_o)
    );

    // R2 / R7: the first beat after a load is the loaded address.
    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(start_i));

    // R6: idle cycles keep the address.
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(addr_o));

    // R3: in linear order each advance adds one to the address.
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && order_q == ORD_LINEAR)
            |=> addr_o == $past(addr_o) + 1'b1);

    // R4: in interleaved order the address flips the bits the beat count flips.
    assert_xor_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && order_q == ORD_INTERLEAVE)
            |=> (addr_o ^ $past(addr_o)) == ($past(beat_q) ^ ($past(beat_q) + 1'b1)));

endmodule

// File: tb/burst_addr_seq_bench.sv
// Scoreboard bench: the driver applies a cycle and pushes the expected
// address; the monitor pops and compares on the following falling edge.
module burst_addr_seq_bench;

    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [BW-1:0] start_i = '0;
    logic          adv_i = 1'b0;
    logic          order_sel_i = 1'b1;
    logic [BW-1:0] addr_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [BW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference state, written from the requirements.
    logic [BW-1:0] m_start = '0;
    logic [BW-1:0] m_beat  = '0;
    bit            m_lin   = 1'b0;

    burst_addr_seq #(.BEAT_W(BW)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
        .adv_i(adv_i), .order_sel_i(order_sel_i), .addr_o(addr_o)
    );

    always #4 clk = ~clk;

    function automatic logic [BW-1:0] model_addr();
        return m_lin ? (m_start + m_beat) : (m_start ^ m_beat);
    endfunction

    // Apply one cycle, update the model, queue the expected output.
    task automatic step(input bit ld, input logic [BW-1:0] st, input bit adv,
                        input bit sel, input string tag);
        @(negedge clk);
        load_i = ld; start_i = st; adv_i = adv; order_sel_i = sel;
        @(posedge clk);
        if (ld) begin
            m_start = st; m_beat = '0; m_lin = (sel == 1'b0);
        end else if (adv) begin
            m_beat = m_beat + 1'b1;
        end
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
    endtask

    // Monitor: compare every queued expectation on the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            logic [BW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (addr_o !== e) begin
                n_bad++;
                $display("FAIL %s: addr_o=%b expected=%b", t, addr_o, e);
            end
        end
    end

    initial begin
        // R1: reset state, during reset and right after release.
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (addr_o !== 2'b00) begin
            n_bad++; $display("FAIL R1: addr_o=%b expected=00 in reset", addr_o);
        end
        rst_n = 1'b1;
        step(0, 2'b00, 0, 1, "R1");

        // R3: linear order from every start, five advances (R5 wrap).
        for (int s = 0; s < 4; s++) begin
            step(1, s[BW-1:0], 0, 0, "R2");
            for (int k = 0; k < 5; k++) step(0, 2'b00, 1, 0, (k == 4) ? "R5" : "R3");
        end

        // R4: interleaved order from every start, six advances (R5 wrap).
        for (int s = 0; s < 4; s++) begin
            step(1, s[BW-1:0], 0, 1, "R2");
            for (int k = 0; k < 6; k++) step(0, 2'b00, 1, 1, (k >= 4) ? "R5" : "R4");
        end

        // R6: idle cycles in the middle of a burst hold the address.
        step(1, 2'b10, 0, 0, "R2");
        step(0, 2'b00, 1, 0, "R3");
        for (int k = 0; k < 3; k++) step(0, 2'b01, 0, 1, "R6");
        step(0, 2'b00, 1, 0, "R3");

        // R7: load together with advance, at every start and both orders.
        for (int s = 0; s < 4; s++) begin
            step(0, 2'b00, 1, 1, "R7");
            step(1, s[BW-1:0], 1, s[0], "R7");
            step(0, 2'b00, 1, s[0], "R7");
        end

        // R8: toggle the order pin mid-burst; captured order must persist.
        step(1, 2'b01, 0, 1, "R2");
        for (int k = 0; k < 4; k++) step(0, 2'b00, 1, k[0], "R8");
        step(1, 2'b01, 0, 0, "R8");
        for (int k = 0; k < 4; k++) step(0, 2'b00, 1, ~k[0], "R8");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule